// File: doc/BRIEF.md
# Hot-Plug Controller Event Latch and Mask Register

This block is one 32-bit control/status word of a hot-plug controller. It watches two controller-wide conditions. The first is an arbiter timeout, which arrives as a pulse. The second is a command completion, which is taken to mean that the controller-busy flag has fallen from 1 to 0. Each condition sets its own sticky event bit. Software clears an event bit by writing 1 to it.

Four read-write mask bits sit in the same word. They decide whether the latched events reach two request outputs: a level interrupt request and a non-fatal error request. The masks act only on these outputs. An event is always recorded, whatever the mask settings.

Software reaches the word through a simple register port. The port has an address, per-byte write enables and a combinational read-data path. The word answers only at byte offset 20h.

Top module: `hpc_evt_reg`

## Requirements
- R1: After reset, offset 20h reads 0000000Fh and both request outputs are low. Any other offset reads 00000000h.
- R2: A cycle with `arb_tmo_i` high sets bit 17 at that clock edge. Bit 17 then stays set until software clears it.
- R3: Bit 16 is set at the edge where `busy_i` is sampled 0 after being sampled 1 at the previous edge. A rising or steady `busy_i` sets nothing. The first edge after reset release never sets bit 16.
- R4: A write to offset 20h with byte lane 2 enabled clears bit 17 where data bit 17 is 1, and clears bit 16 where data bit 16 is 1. Writing 0 to these bits leaves them unchanged.
- R5: If an event set and a write-1 clear of the same bit fall in the same cycle, the bit ends set.
- R6: Mask bits 3:0 take data bits 3:0 only on a write to offset 20h with byte lane 0 enabled. Writes with lane 0 disabled, or to any other offset, leave them unchanged.
- R7: Bits 31:18 and 15:4 read as 0. Writing 1s to them has no effect.
- R8: `irq_o` is high exactly when bit 16 is 1, bit 2 is 0 and bit 0 is 0. It stays high until that no longer holds.
- R9: `err_req_o` is high exactly when bit 17 is 1, bit 3 is 0, bit 1 is 0, and either `cmd_err_en_i` or `nf_msg_en_i` is 1.
- R10: Mask bits never stop bits 16 or 17 from being set.
- R11: Both request outputs follow the register state and the enable inputs without added delay. They change just after the edge that changes a bit, or at once when an enable input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_be_i | input | DATA_W/8 | Byte-lane write enables |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| busy_i | input | 1 | Controller-busy flag |
| arb_tmo_i | input | 1 | Arbiter-timeout pulse |
| cmd_err_en_i | input | 1 | Error enable from the command register |
| nf_msg_en_i | input | 1 | Non-fatal message enable from the capability |
| irq_o | output | 1 | Interrupt request, level |
| err_req_o | output | 1 | Non-fatal error request, level |

## Verification
Wrong internal state shows up at the ports by the next readback. For example, a lost busy edge, a clear that wins over a set, or a mask that changed without a valid write all appear in the read data at 20h just after the edge concerned. Because both requests are combinational from the stored bits, a bad event or mask bit also moves `irq_o` or `err_req_o` in the same cycle. The bench therefore samples the read data and both outputs one step after each edge. It does this in particular at the first edge after reset and in the cycle where a set and a clear collide.

// File: rtl/hpc_evt_pkg.sv
package hpc_evt_pkg;

  localparam int unsigned EV_CMP_POS   = 16;
  localparam int unsigned EV_ARB_POS   = 17;
  localparam int unsigned MSK_GIRQ_POS = 0;
  localparam int unsigned MSK_GERR_POS = 1;
  localparam int unsigned MSK_CMP_POS  = 2;
  localparam int unsigned MSK_ARB_POS  = 3;
  localparam int unsigned N_EV         = 2;
  localparam int unsigned N_MSK        = 4;

  typedef struct packed {
    logic arb;
    logic cmp;
  } ev_t;

  typedef struct packed {
    logic arb;
    logic cmp;
    logic gerr;
    logic girq;
  } msk_t;

  localparam msk_t MSK_RST = '{arb: 1'b1, cmp: 1'b1, gerr: 1'b1, girq: 1'b1};

  function automatic int unsigned lane_of(input int unsigned pos);
    return pos / 8;
  endfunction

endpackage

// File: rtl/hpc_evt_fall.sv
module hpc_evt_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);

  logic lvl_q;

  // reset to 0: a flag high through reset yields no edge on the first clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;

endmodule

// File: rtl/hpc_evt_latch.sv
module hpc_evt_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    // set wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end

endmodule

// File: rtl/hpc_evt_mask.sv
module hpc_evt_mask #(
  parameter int unsigned N   = 4,
  parameter logic [N-1:0] RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/hpc_evt_gate.sv
module hpc_evt_gate
  import hpc_evt_pkg::*;
(
  input  ev_t  ev_i,
  input  msk_t msk_i,
  input  logic cmd_err_en_i,
  input  logic nf_msg_en_i,
  output logic irq_o,
  output logic err_o
);

  logic err_path_en;

  assign err_path_en = cmd_err_en_i | nf_msg_en_i;
  assign irq_o       = ev_i.cmp & ~msk_i.cmp & ~msk_i.girq;
  assign err_o       = ev_i.arb & ~msk_i.arb & ~msk_i.gerr & err_path_en;

endmodule

// File: rtl/hpc_evt_reg.sv
module hpc_evt_reg
  import hpc_evt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_OFS = 'h20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W/8-1:0] wr_be_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic                busy_i,
  input  logic                arb_tmo_i,
  input  logic                cmd_err_en_i,
  input  logic                nf_msg_en_i,
  output logic                irq_o,
  output logic                err_req_o
);

  localparam int unsigned BE_W     = DATA_W / 8;
  localparam int unsigned LANE_EV  = lane_of(EV_ARB_POS);
  localparam int unsigned LANE_MSK = lane_of(N_MSK - 1);

  logic            addr_hit, wr_hit;
  logic            cmp_fall;
  logic [N_EV-1:0] ev_set, ev_clr, ev_raw;
  logic [N_MSK-1:0] msk_raw;
  ev_t             ev_q;
  msk_t            msk_q;
  logic [DATA_W-1:0] img;
  logic            unused_wr;

  assign addr_hit = (addr_i == ADDR_W'(REG_OFS));
  assign wr_hit   = wr_en_i & addr_hit;

  hpc_evt_fall u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (busy_i),
    .fall_o (cmp_fall)
  );

  assign ev_set = {arb_tmo_i, cmp_fall};
  assign ev_clr = {wr_data_i[EV_ARB_POS], wr_data_i[EV_CMP_POS]}
                  & {N_EV{wr_hit & wr_be_i[LANE_EV]}};

  hpc_evt_latch #(.N(N_EV)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .q_o    (ev_raw)
  );
  assign ev_q = ev_t'(ev_raw);

  hpc_evt_mask #(.N(N_MSK), .RST(MSK_RST)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_hit & wr_be_i[LANE_MSK]),
    .d_i    (wr_data_i[N_MSK-1:0]),
    .q_o    (msk_raw)
  );
  assign msk_q = msk_t'(msk_raw);

  hpc_evt_gate u_gate (
    .ev_i         (ev_q),
    .msk_i        (msk_q),
    .cmd_err_en_i (cmd_err_en_i),
    .nf_msg_en_i  (nf_msg_en_i),
    .irq_o        (irq_o),
    .err_o        (err_req_o)
  );

  always_comb begin
    img                = '0;
    img[EV_ARB_POS]    = ev_q.arb;
    img[EV_CMP_POS]    = ev_q.cmp;
    img[N_MSK-1:0]     = msk_q;
  end

  assign rd_data_o = addr_hit ? img : '0;

  assign unused_wr = ^{wr_data_i, wr_be_i, BE_W[0]};

endmodule

// File: rtl/hpc_evt_reg_chk.sv
module hpc_evt_reg_chk
  import hpc_evt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_OFS = 'h20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic [DATA_W/8-1:0] wr_be_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic                busy_i,
  input logic                arb_tmo_i,
  input logic                cmd_err_en_i,
  input logic                nf_msg_en_i,
  input logic                irq_o,
  input logic                err_req_o,
  input ev_t                 ev_i,
  input msk_t                msk_i
);

  logic hit, clr_arb, clr_cmp, msk_we, unused_chk;

  assign hit     = wr_en_i && (addr_i == ADDR_W'(REG_OFS));
  assign clr_arb = hit && wr_be_i[lane_of(EV_ARB_POS)] && wr_data_i[EV_ARB_POS];
  assign clr_cmp = hit && wr_be_i[lane_of(EV_CMP_POS)] && wr_data_i[EV_CMP_POS];
  assign msk_we  = hit && wr_be_i[0];
  assign unused_chk = ^wr_data_i;

  assert_arb_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_tmo_i |=> ev_i.arb);

  assert_arb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.arb && !clr_arb |=> ev_i.arb);

  assert_cmp_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $fell(busy_i) |=> ev_i.cmp);

  assert_cmp_no_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.cmp && busy_i |=> !ev_i.cmp);

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmp && busy_i |=> !ev_i.cmp);

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_tmo_i && clr_arb |=> ev_i.arb);

  assert_msk_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msk_we |=> $stable(msk_i));

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ev_i.cmp && !msk_i.cmp && !msk_i.girq);

  assert_err_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_req_o |-> ev_i.arb && !msk_i.arb && !msk_i.gerr && (cmd_err_en_i || nf_msg_en_i));

endmodule

bind hpc_evt_reg hpc_evt_reg_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .REG_OFS(REG_OFS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_en_i      (wr_en_i),
  .wr_be_i      (wr_be_i),
  .wr_data_i    (wr_data_i),
  .busy_i       (busy_i),
  .arb_tmo_i    (arb_tmo_i),
  .cmd_err_en_i (cmd_err_en_i),
  .nf_msg_en_i  (nf_msg_en_i),
  .irq_o        (irq_o),
  .err_req_o    (err_req_o),
  .ev_i         (ev_q),
  .msk_i        (msk_q)
);

// File: tb/hpc_evt_reg_bench.sv
module hpc_evt_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS = 8'h20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = OFS;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        busy_i = 1'b1;
  logic        arb_tmo_i = 1'b0;
  logic        cmd_err_en_i = 1'b0;
  logic        nf_msg_en_i = 1'b0;
  logic        irq_o, err_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  hpc_evt_reg u_hpc_evt_reg (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_be_i, .wr_data_i, .rd_data_o,
    .busy_i, .arb_tmo_i, .cmd_err_en_i, .nf_msg_en_i, .irq_o, .err_req_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rd_data_o; addr_i = OFS;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wr_be_i = be; wr_data_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0; wr_be_i = '0; addr_i = OFS;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_ni = 1'b0; busy_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    tick();
    rd(OFS, d); chk("R1 reset value", d, 32'h0000_000F);
    chk("R1 irq low", {31'b0, irq_o}, 0);
    chk("R1 err low", {31'b0, err_req_o}, 0);
    rd(8'h24, d); chk("R1 other offset", d, 0);
    tick();
    rd(OFS, d); chk("R3 no event after reset", d, 32'h0000_000F);
  endtask

  task automatic t_mask_latch();
    logic [31:0] d;
    @(negedge clk_i); busy_i = 1'b0;
    tick();
    rd(OFS, d); chk("R10 masked fall still latched", d, 32'h0001_000F);
    chk("R8 irq masked", {31'b0, irq_o}, 0);
    wr(OFS, 4'b0100, 32'h0001_0000);
    rd(OFS, d); chk("R4 clear bit16", d, 32'h0000_000F);
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    wr(OFS, 4'b1110, 32'h0000_0000);
    rd(OFS, d); chk("R6 lane0 off keeps masks", d, 32'h0000_000F);
    wr(8'h24, 4'b1111, 32'h0000_0000);
    rd(OFS, d); chk("R6 other offset ignored", d, 32'h0000_000F);
    wr(OFS, 4'b0001, 32'h0000_0000);
    rd(OFS, d); chk("R6 masks written", d, 0);
    wr(OFS, 4'b1111, 32'hFFFC_FFF0);
    rd(OFS, d); chk("R7 reserved read zero", d, 0);
  endtask

  task automatic t_cmp();
    logic [31:0] d;
    @(negedge clk_i); busy_i = 1'b1;
    tick(); tick();
    rd(OFS, d); chk("R3 rise no event", d, 0);
    @(negedge clk_i); busy_i = 1'b0;
    tick();
    rd(OFS, d); chk("R3 fall sets bit16", d, 32'h0001_0000);
    chk("R11 irq same cycle", {31'b0, irq_o}, 1);
    wr(OFS, 4'b0001, 32'h4);
    chk("R8 irq cmp mask", {31'b0, irq_o}, 0);
    wr(OFS, 4'b0001, 32'h1);
    chk("R8 irq global mask", {31'b0, irq_o}, 0);
    wr(OFS, 4'b0001, 32'h0);
    chk("R8 irq level held", {31'b0, irq_o}, 1);
    wr(OFS, 4'b0100, 32'h0);
    rd(OFS, d); chk("R4 write 0 keeps", d, 32'h0001_0000);
    wr(OFS, 4'b0100, 32'h0001_0000);
    rd(OFS, d); chk("R4 w1c bit16", d, 0);
    chk("R8 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    @(negedge clk_i); arb_tmo_i = 1'b1;
    tick();
    @(negedge clk_i); arb_tmo_i = 1'b0;
    tick(); tick();
    rd(OFS, d); chk("R2 sticky bit17", d, 32'h0002_0000);
    chk("R9 no enable", {31'b0, err_req_o}, 0);
    cmd_err_en_i = 1'b1; #1;
    chk("R9 cmd enable", {31'b0, err_req_o}, 1);
    cmd_err_en_i = 1'b0; nf_msg_en_i = 1'b1; #1;
    chk("R9 nf enable", {31'b0, err_req_o}, 1);
    wr(OFS, 4'b0001, 32'h8);
    chk("R9 arb mask", {31'b0, err_req_o}, 0);
    wr(OFS, 4'b0001, 32'h2);
    chk("R9 global mask", {31'b0, err_req_o}, 0);
    rd(OFS, d); chk("R10 bit17 kept under mask", d, 32'h0002_0002);
    wr(OFS, 4'b0001, 32'h0);
    chk("R9 unmasked", {31'b0, err_req_o}, 1);
    wr(OFS, 4'b0100, 32'h0002_0000);
    rd(OFS, d); chk("R4 w1c bit17", d, 0);
    chk("R9 err drops", {31'b0, err_req_o}, 0);
    nf_msg_en_i = 1'b0;
  endtask

  task automatic t_prio();
    logic [31:0] d;
    @(negedge clk_i); busy_i = 1'b1;
    tick();
    @(negedge clk_i); arb_tmo_i = 1'b1; busy_i = 1'b0;
    addr_i = OFS; wr_be_i = 4'b0100; wr_data_i = 32'h0003_0000; wr_en_i = 1'b1;
    tick();
    arb_tmo_i = 1'b0; wr_en_i = 1'b0; wr_be_i = '0;
    rd(OFS, d); chk("R5 set beats clear", d, 32'h0003_0000);
    wr(OFS, 4'b0100, 32'h0003_0000);
    rd(OFS, d); chk("R5 later clear works", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mask_latch();
    t_mask_rw();
    t_cmp();
    t_arb();
    t_prio();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule